// File: doc/BRIEF.md
# Virtual Address Translation and Protection Unit

This block turns a 32-bit virtual address into a physical address for a fetch, a data read or a data write. It first applies fixed rules for the untranslated high regions. It then honours the translation-enable bit. Every other address is resolved from the result of a unified TLB lookup that lives outside this block. For a translated access, the lookup result supplies the hit and multiple-hit flags, the page frame number, the size code, the two-bit protection field and the dirty bit. The block combines these with the access kind and the privilege bit. It produces a physical address, an OK flag and a 12-bit exception code, all registered one cycle after the request strobe.

The block also drives a combinational flag that tells the external lookup whether the address-space identifier takes part in the match. It also keeps the 6-bit replacement counter used to pick the TLB slot for the next refill. That counter steps on each request that reaches the unified lookup. It returns to zero when it reaches a programmable limit or the last slot index.

Top module: `vaddr_xlate`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. `rsp_valid` is never high without such a request.
- R2: In privileged mode, an address in 0x80000000–0xBFFFFFFF or at or above 0xFC000000 succeeds with its top 3 bits cleared. An address in 0xE0000000–0xFBFFFFFF succeeds unchanged. None of these uses the lookup.
- R3: In user mode, the untranslated regions of R2 are usable only from 0xE0000000 to 0xE4000000 inclusive, with the R2 mapping. Any other address in them fails with code 0x100 for a write, and 0x0E0 for a read or a fetch.
- R4: With `xlate_en` low, every address outside the R2 regions succeeds as its low 29 bits, for any access kind and mode.
- R5: `asid_cmp_en` is low exactly when `single_space` and `priv_mode` are both high.
- R6: A translated access with `lut_multi` high fails with 0x140, whether or not `lut_hit` is high. A translated access with no hit fails with 0x060 for a write, and 0x040 for a read or a fetch.
- R7: On a hit, `lut_prot` encodes the following permissions. 00: privileged read only. 01: privileged read and write, no user access. 10: read only in both modes. 11: read and write in both modes. A denied write fails with 0x0C0; a denied read or fetch fails with 0x0A0. `req_kind` 01 is a write; 00 is a read; 10 and 11 are fetches.
- R8: A permitted write on a hit whose `lut_dirty` is low fails with 0x080. With `lut_dirty` high, the same write succeeds.
- R9: On a successful hit, the physical address is ({`lut_ppn`, 10 zero bits} with the page-offset bits cleared) ORed with the page-offset bits of the virtual address. The size code sets the offset width: 0 gives 10 bits, 1 gives 12, 2 gives 16 and 3 gives 20.
- R10: `repl_ctr` increments once for every request that goes to the lookup (translation enabled, outside the R2 regions). If the incremented value equals `repl_limit` or 63, the counter becomes 0 instead. Other requests leave it unchanged.
- R11: A failed response has `rsp_ok` low, a non-zero code and `rsp_paddr` of 0. A successful response has code 0.
- R12: After reset, `rsp_valid` is low and `repl_ctr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10/11 fetch |
| priv_mode | input | 1 | Privileged mode when high |
| xlate_en | input | 1 | Translation enable |
| single_space | input | 1 | Single virtual space mode |
| repl_limit | input | 6 | Wrap boundary for the replacement counter |
| lut_hit | input | 1 | Lookup found a matching entry |
| lut_multi | input | 1 | Lookup found more than one match |
| lut_ppn | input | 22 | Page frame number of the matching entry |
| lut_size | input | 2 | Page size code of the matching entry |
| lut_prot | input | 2 | Protection field of the matching entry |
| lut_dirty | input | 1 | Dirty bit of the matching entry |
| asid_cmp_en | output | 1 | Lookup must compare address-space identifiers |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_ok | output | 1 | Access permitted |
| rsp_code | output | 12 | Exception code, 0 on success |
| repl_ctr | output | 6 | Replacement counter |

## Verification
The only internal state is the replacement counter and the output register. A wrong counter value is visible on `repl_ctr` at the next clock edge. It stays wrong, so any later wrap at the limit or at 63 lands on the wrong request. The bench compares the counter after every request. A wrong decode of the region, the protection matrix or the dirty check shows up as a wrong code or address on the response one cycle after the request. The sweep of every protection value, mode and direction, and of every size code, makes such an error show up within a few requests.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 10;
  localparam int PPN_W      = VA_W - PAGE_SHIFT;
  localparam int LOW_KEEP   = 29;
  localparam int CODE_W     = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_FETCH_ALT = 2'b11
  } acc_kind_e;

  localparam logic [CODE_W-1:0] EXC_NONE    = 12'h000;
  localparam logic [CODE_W-1:0] EXC_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] EXC_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] EXC_DIRTY   = 12'h080;
  localparam logic [CODE_W-1:0] EXC_VIOL_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] EXC_VIOL_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] EXC_AERR_RD = 12'h0E0;
  localparam logic [CODE_W-1:0] EXC_AERR_WR = 12'h100;
  localparam logic [CODE_W-1:0] EXC_MULTI   = 12'h140;

  localparam logic [VA_W-1:0] SQ_LO = 32'hE000_0000;
  localparam logic [VA_W-1:0] SQ_HI = 32'hE400_0000;

  typedef struct packed {
    logic            ok;
    logic [CODE_W-1:0] code;
    logic [VA_W-1:0] pa;
  } xlate_res_t;
endpackage

// File: rtl/xlate_region_decode.sv
module xlate_region_decode
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic            priv,
  output logic            bypass,
  output logic            denied,
  output logic [VA_W-1:0] bypass_pa
);
  logic in_mid;
  logic in_top;
  logic in_ctrl;
  logic sq_window;
  logic fold;

  always_comb begin
    in_mid    = (vaddr[VA_W-1 -: 2] == 2'b10);
    in_top    = (vaddr[VA_W-1 -: 3] == 3'b111);
    in_ctrl   = (vaddr[VA_W-1 -: 6] == 6'b111111);
    sq_window = (vaddr >= SQ_LO) && (vaddr <= SQ_HI);
    bypass    = in_mid || in_top;
    denied    = bypass && !priv && !sq_window;
    fold      = in_mid || in_ctrl;
    bypass_pa = fold ? {{(VA_W-LOW_KEEP){1'b0}}, vaddr[LOW_KEEP-1:0]} : vaddr;
  end
endmodule

// File: rtl/xlate_prot_check.sv
module xlate_prot_check (
  input  logic [1:0] prot,
  input  logic       priv,
  input  logic       is_write,
  input  logic       dirty,
  output logic       viol,
  output logic       first_write
);
  logic rd_allow;
  logic wr_allow;

  always_comb begin
    rd_allow    = prot[1] | priv;
    wr_allow    = prot[0] & (prot[1] | priv);
    viol        = is_write ? !wr_allow : !rd_allow;
    first_write = is_write && wr_allow && !dirty;
  end
endmodule

// File: rtl/xlate_repl_counter.sv
module xlate_repl_counter #(
  parameter int ENTRIES = 64,
  localparam int CNT_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRIES - 1);

  logic [CNT_W-1:0] bumped;

  always_comb begin
    bumped = count + CNT_W'(1);
    if (bumped == limit || bumped == LAST) bumped = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= bumped;
  end

  // R10
  ctr_never_last_chk: assert property (@(posedge clk) disable iff (rst)
    count != LAST);
  // R10
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
  // R10
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (count == $past(count) + CNT_W'(1)) || (count == '0));
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int CNT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              priv_mode,
  input  logic              xlate_en,
  input  logic              single_space,
  input  logic [CNT_W-1:0]  repl_limit,
  input  logic              lut_hit,
  input  logic              lut_multi,
  input  logic [PPN_W-1:0]  lut_ppn,
  input  logic [1:0]        lut_size,
  input  logic [1:0]        lut_prot,
  input  logic              lut_dirty,
  output logic              asid_cmp_en,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_ok,
  output logic [CODE_W-1:0] rsp_code,
  output logic [CNT_W-1:0]  repl_ctr
);
  localparam int N_SIZES = 4;

  acc_kind_e       kind;
  logic            is_write;
  logic            bypass;
  logic            denied;
  logic [VA_W-1:0] bypass_pa;
  logic            viol;
  logic            first_write;
  logic            lookup;
  logic [VA_W-1:0] off_mask;
  logic [VA_W-1:0] page_pa;
  xlate_res_t      res;

  logic [VA_W-1:0] size_mask [N_SIZES];
  genvar gi;
  generate
    for (gi = 0; gi < N_SIZES; gi++) begin : g_mask
      localparam int SHIFT = (gi == 0) ? PAGE_SHIFT :
                             (gi == 1) ? PAGE_SHIFT + 2 :
                             (gi == 2) ? PAGE_SHIFT + 6 : PAGE_SHIFT + 10;
      assign size_mask[gi] = (VA_W'(1) << SHIFT) - VA_W'(1);
    end
  endgenerate

  assign kind        = acc_kind_e'(req_kind);
  assign is_write    = (kind == ACC_WRITE);
  assign asid_cmp_en = !(single_space && priv_mode);

  xlate_region_decode u_region (
    .vaddr     (req_vaddr),
    .priv      (priv_mode),
    .bypass    (bypass),
    .denied    (denied),
    .bypass_pa (bypass_pa)
  );

  xlate_prot_check u_prot (
    .prot        (lut_prot),
    .priv        (priv_mode),
    .is_write    (is_write),
    .dirty       (lut_dirty),
    .viol        (viol),
    .first_write (first_write)
  );

  always_comb begin
    off_mask = size_mask[lut_size];
    page_pa  = ({lut_ppn, {PAGE_SHIFT{1'b0}}} & ~off_mask) | (req_vaddr & off_mask);
  end

  always_comb begin
    lookup = 1'b0;
    res    = '{ok: 1'b0, code: EXC_NONE, pa: '0};
    if (bypass) begin
      if (denied) res.code = is_write ? EXC_AERR_WR : EXC_AERR_RD;
      else        res = '{ok: 1'b1, code: EXC_NONE, pa: bypass_pa};
    end else if (!xlate_en) begin
      res = '{ok: 1'b1, code: EXC_NONE,
              pa: {{(VA_W-LOW_KEEP){1'b0}}, req_vaddr[LOW_KEEP-1:0]}};
    end else begin
      lookup = 1'b1;
      if (lut_multi)        res.code = EXC_MULTI;
      else if (!lut_hit)    res.code = is_write ? EXC_MISS_WR : EXC_MISS_RD;
      else if (viol)        res.code = is_write ? EXC_VIOL_WR : EXC_VIOL_RD;
      else if (first_write) res.code = EXC_DIRTY;
      else                  res = '{ok: 1'b1, code: EXC_NONE, pa: page_pa};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_code  <= EXC_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok    <= res.ok;
        rsp_code  <= res.code;
        rsp_paddr <= res.pa;
      end
    end
  end

  xlate_repl_counter #(.ENTRIES(ENTRIES)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .step  (req_valid && lookup),
    .limit (repl_limit),
    .count (repl_ctr)
  );

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R11
  fault_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0 && rsp_code != EXC_NONE));
  // R7
  user_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lookup && lut_hit && !lut_multi && !priv_mode && !lut_prot[1])
      |=> (!rsp_ok && rsp_code == EXC_VIOL_RD) || (!rsp_ok && rsp_code == EXC_VIOL_WR));
  // R3
  user_region_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv_mode && req_vaddr[VA_W-1 -: 2] == 2'b10) |=> !rsp_ok);
endmodule

// File: tb/vaddr_xlate_bench.sv
module vaddr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        priv_mode = 1'b0, xlate_en = 1'b0, single_space = 1'b0;
  logic [5:0]  repl_limit = 6'd0;
  logic        lut_hit = 1'b0, lut_multi = 1'b0, lut_dirty = 1'b0;
  logic [21:0] lut_ppn = '0;
  logic [1:0]  lut_size = '0, lut_prot = '0;
  logic        asid_cmp_en, rsp_valid, rsp_ok;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_code;
  logic [5:0]  repl_ctr;

  typedef struct packed {
    logic        ok;
    logic [11:0] code;
    logic [31:0] pa;
    logic [5:0]  cnt;
    logic [7:0]  rq;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic [5:0] model_cnt = '0;

  always #10 clk = ~clk;

  vaddr_xlate u_vaddr_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .priv_mode(priv_mode), .xlate_en(xlate_en),
    .single_space(single_space), .repl_limit(repl_limit), .lut_hit(lut_hit),
    .lut_multi(lut_multi), .lut_ppn(lut_ppn), .lut_size(lut_size),
    .lut_prot(lut_prot), .lut_dirty(lut_dirty), .asid_cmp_en(asid_cmp_en),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ok(rsp_ok),
    .rsp_code(rsp_code), .repl_ctr(repl_ctr)
  );

  task automatic check(input bit cond, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Driver: applies one request at a falling edge and queues the expected result.
  task automatic go(input logic [31:0] va, input logic [1:0] k, input logic p,
                    input logic en, input logic hit, input logic mul,
                    input logic [21:0] ppn, input logic [1:0] sz,
                    input logic [1:0] pr, input logic d, input int rq);
    exp_t e;
    bit wr, mid, top, ctrl, sq, byp, look;
    logic [31:0] m;
    logic [5:0] nx;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; priv_mode = p;
    xlate_en = en; lut_hit = hit; lut_multi = mul; lut_ppn = ppn;
    lut_size = sz; lut_prot = pr; lut_dirty = d;
    wr   = (k == 2'b01);
    mid  = (va >= 32'h8000_0000) && (va < 32'hC000_0000);
    top  = (va >= 32'hE000_0000);
    ctrl = (va >= 32'hFC00_0000);
    sq   = (va >= 32'hE000_0000) && (va <= 32'hE400_0000);
    byp  = mid || top;
    look = !byp && en;
    e = '0;
    e.rq = 8'(rq);
    if (byp) begin
      if (!p && !sq) e.code = wr ? 12'h100 : 12'h0E0;
      else begin e.ok = 1'b1; e.pa = (mid || ctrl) ? (va & 32'h1FFF_FFFF) : va; end
    end else if (!en) begin
      e.ok = 1'b1; e.pa = va & 32'h1FFF_FFFF;
    end else if (mul) e.code = 12'h140;
    else if (!hit) e.code = wr ? 12'h060 : 12'h040;
    else begin
      bit rd_ok, wr_ok;
      rd_ok = (pr == 2'b10) || (pr == 2'b11) || p;
      wr_ok = (pr == 2'b11) || (pr == 2'b01 && p);
      if (wr ? !wr_ok : !rd_ok) e.code = wr ? 12'h0C0 : 12'h0A0;
      else if (wr && !d) e.code = 12'h080;
      else begin
        case (sz)
          2'd0: m = 32'h0000_03FF;
          2'd1: m = 32'h0000_0FFF;
          2'd2: m = 32'h0000_FFFF;
          default: m = 32'h000F_FFFF;
        endcase
        e.ok = 1'b1;
        e.pa = ({ppn, 10'b0} & ~m) | (va & m);
      end
    end
    if (look) begin
      nx = model_cnt + 6'd1;
      if (nx == repl_limit || nx == 6'd63) nx = 6'd0;
      model_cnt = nx;
    end
    e.cnt = model_cnt;
    exp_q.push_back(e);
    #1;
    // R5: asid compare flag follows mode bits combinationally
    check(asid_cmp_en == !(single_space && p), 5, "asid_cmp_en",
          32'(asid_cmp_en), 32'(!(single_space && p)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares each response against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 1, "unexpected rsp_valid", 32'(rsp_valid), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_ok == e.ok, int'(e.rq), "rsp_ok", 32'(rsp_ok), 32'(e.ok));
        check(rsp_code == e.code, int'(e.rq), "rsp_code", 32'(rsp_code), 32'(e.code));
        check(rsp_paddr == e.pa, int'(e.rq), "rsp_paddr", rsp_paddr, e.pa);
        // R10: counter after every request
        check(repl_ctr == e.cnt, 10, "repl_ctr", 32'(repl_ctr), 32'(e.cnt));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(rsp_valid == 1'b0, 12, "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check(repl_ctr == 6'd0, 12, "repl_ctr in reset", 32'(repl_ctr), 32'h0);
    rst = 1'b0;
    idle(2);
    // R1: no response without request
    check(rsp_valid == 1'b0, 1, "idle rsp_valid", 32'(rsp_valid), 32'h0);

    // R2: privileged untranslated regions
    go(32'h8123_4567, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    go(32'hA000_0000, 2'b10, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    go(32'hFF00_0010, 2'b01, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    go(32'hE100_0000, 2'b01, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    go(32'hFBFF_FFFC, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    // R3: user mode in untranslated regions
    go(32'hE000_0000, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, 3);
    go(32'hE400_0000, 2'b01, 0, 1, 0, 0, 0, 0, 0, 0, 3);
    go(32'hE400_0004, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, 3);
    go(32'h8000_0000, 2'b01, 0, 1, 0, 0, 0, 0, 0, 0, 3);
    go(32'hFC00_0000, 2'b10, 0, 1, 0, 0, 0, 0, 0, 0, 3);
    // R4: translation disabled, lookup fields ignored
    go(32'h7FFF_FFFF, 2'b01, 0, 0, 1, 1, 22'h3FFFFF, 3, 0, 0, 4);
    go(32'hC123_4567, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 4);
    // R5: single space with privilege
    single_space = 1'b1;
    go(32'h0000_1000, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 5);
    go(32'h0000_1000, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 5);
    single_space = 1'b0;
    // R6: misses and multiple hits
    go(32'h0000_2000, 2'b00, 1, 1, 0, 0, 0, 0, 3, 1, 6);
    go(32'h0000_2000, 2'b01, 1, 1, 0, 0, 0, 0, 3, 1, 6);
    go(32'h0000_2000, 2'b10, 0, 1, 0, 0, 0, 0, 3, 1, 6);
    go(32'h0000_2000, 2'b00, 1, 1, 1, 1, 0, 0, 3, 1, 6);
    go(32'h0000_2000, 2'b01, 1, 1, 0, 1, 0, 0, 3, 1, 6);
    // R7: full protection matrix with dirty set
    for (int pr = 0; pr < 4; pr++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          go(32'h0040_0ABC, w ? 2'b01 : 2'b00, p[0], 1, 1, 0, 22'h000123,
             1, pr[1:0], 1, 7);
    go(32'h0040_0ABC, 2'b11, 0, 1, 1, 0, 22'h000123, 1, 2'b01, 1, 7);
    // R8: initial write on clean page
    go(32'h0040_0ABC, 2'b01, 0, 1, 1, 0, 22'h000123, 1, 2'b11, 0, 8);
    go(32'h0040_0ABC, 2'b01, 1, 1, 1, 0, 22'h000123, 1, 2'b01, 0, 8);
    go(32'h0040_0ABC, 2'b01, 1, 1, 1, 0, 22'h000123, 1, 2'b00, 0, 8);
    go(32'h0040_0ABC, 2'b00, 0, 1, 1, 0, 22'h000123, 1, 2'b10, 0, 8);
    // R9: each page size
    for (int sz = 0; sz < 4; sz++)
      go(32'h1234_5678, 2'b00, 1, 1, 1, 0, 22'h2AAAAA, sz[1:0], 2'b11, 1, 9);
    idle(2);
    // R10: wrap at programmed limit, then at last index
    repl_limit = model_cnt + 6'd3;
    for (int i = 0; i < 5; i++)
      go(32'h0000_3000, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 10);
    repl_limit = 6'd0;
    for (int i = 0; i < 70; i++)
      go(32'h0000_3000, 2'b10, 1, 1, 1, 0, 22'h1, 0, 2'b10, 1, 10);
    idle(3);
    // R1: every request answered exactly once
    check(exp_q.size() == 0, 1, "outstanding responses", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule